// File: doc/BRIEF.md
# Conditional Return Sequencer

This unit is the slice of an 8-bit CPU's micro-sequencer that carries out return instructions. It accepts one fetched opcode byte through a valid/ready handshake. It compares that byte against the eight flag-conditioned return encodings and the unconditional return, and it reads the sign, zero, parity/overflow and carry flags. When the return is taken, it pops a 16-bit return address from the stack through a memory read port, loads it into the program counter and moves the stack pointer up by two. When the condition fails, it goes through a dedicated pass-back state that writes nothing. It then returns control to fetch, and the byte that follows the return opcode is left for the next instruction.

Back-pressure rules apply at both edges. On the opcode side, `op_byte` and the flags must stay stable while `op_valid` is high. `op_ready` is high only while the unit is idle and the presented byte is a return opcode, so any other byte is never consumed. On the memory side, `rd_addr` holds steady while `rd_valid` is high and `rd_ready` is low. Only one read is outstanding at a time. `rd_rvalid` carries the read byte for one cycle, at least one cycle after the request was accepted, and it cannot be stalled.

Top module: `cond_return_unit`

## Requirements
- R1: `op_ready` is high exactly when the unit is idle and `op_byte` is 8'hC9 or has the form 2'b11, ccc, 3'b000. No other byte is ever accepted.
- R2: The condition field ccc = `op_byte[5:3]` selects a flag through ccc[2:1] (0 zero, 1 carry, 2 parity/overflow, 3 sign). ccc[0] gives the flag value for which the return is taken: C0 NZ, C8 Z, D0 NC, D8 C, E0 PO, E8 PE, F0 P, F8 M.
- R3: A taken return first reads address SP and then reads SP+1, with the addition wrapping at 16 bits. It then writes `pc_out` = {byte at SP+1, byte at SP} with `pc_we`, and `sp_out` = SP+2 with `sp_we`, in the same cycle.
- R4: Opcode C9 is always taken, whatever the flags are.
- R5: A return that is not taken raises `done` in the first cycle after acceptance. It never raises `pc_we`, `sp_we` or `rd_valid`, so the program counter keeps pointing just past the return opcode and the stack pointer is unchanged.
- R6: In the cycle after `done`, the unit is idle again (`phase_o` = 0). The next byte is not swallowed: a non-return byte offered then still sees `op_ready` low.
- R7: `done` is a single-cycle pulse, raised exactly once for each accepted opcode, on both paths.
- R8: While `rd_valid` is high and `rd_ready` is low, `rd_valid` stays high and `rd_addr` stays stable.
- R9: `phase_o` encodes 0 for idle, 1 for popping (read issued or awaited) and 2 for handing back to fetch. The value 2 coincides with `done`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| op_valid | input | 1 | Opcode byte offered |
| op_ready | output | 1 | Opcode byte accepted this cycle when valid |
| op_byte | input | 8 | Fetched opcode |
| flag_s | input | 1 | Sign flag |
| flag_z | input | 1 | Zero flag |
| flag_pv | input | 1 | Parity/overflow flag |
| flag_c | input | 1 | Carry flag |
| sp_in | input | 16 | Current stack pointer, sampled on acceptance |
| rd_valid | output | 1 | Stack read request |
| rd_ready | input | 1 | Memory accepts the request |
| rd_addr | output | 16 | Stack read address |
| rd_rvalid | input | 1 | Read data valid |
| rd_rdata | input | 8 | Read data byte |
| pc_we | output | 1 | Program counter write strobe |
| pc_out | output | 16 | New program counter value |
| sp_we | output | 1 | Stack pointer write strobe |
| sp_out | output | 16 | New stack pointer value |
| done | output | 1 | Control handed back to fetch |
| phase_o | output | 2 | Main state: 0 idle, 1 popping, 2 hand-back |

## Verification
The bench checks every one of the 256 byte values for acceptance at idle. It runs all nine return opcodes against all sixteen flag combinations, using stack pointers that include 16'hFFFF and 16'hFFFE so that the wrapping address arithmetic is exercised. A decoder that fell into a default state on a failed condition would swallow the following byte or hang without `done`. The bench catches that case by offering a non-return byte right after hand-back and by checking the position of the `done` pulse. The memory model stalls `rd_ready` every third cycle, so a request that moved or dropped under back-pressure would be seen. A swapped byte order or a wrong stack step would show up in the program counter and stack pointer values. A directed sequence reproduces a compare that clears zero followed by a return-if-zero. It confirms that the stack pointer is untouched, so the following push lands at 16'h07FE and 16'h07FD.

// File: rtl/cru_pkg.sv
package cru_pkg;

  localparam int OP_W = 8;
  localparam logic [OP_W-1:0] RET_ALWAYS = 8'hC9;

  // micro-states of the return sequencer
  typedef enum logic [2:0] {
    S_IDLE  = 3'd0,
    S_PASS  = 3'd1,  // condition false: explicit no-write hand-back
    S_RQ_LO = 3'd2,
    S_WT_LO = 3'd3,
    S_RQ_HI = 3'd4,
    S_WT_HI = 3'd5,
    S_LOAD  = 3'd6
  } seq_state_e;

  // externally visible phase
  localparam logic [1:0] PH_IDLE     = 2'd0;
  localparam logic [1:0] PH_POP      = 2'd1;
  localparam logic [1:0] PH_HANDBACK = 2'd2;

endpackage

// File: rtl/cru_cond_eval.sv
module cru_cond_eval
  import cru_pkg::*;
(
  input  logic [OP_W-1:0] op_byte,
  input  logic            flag_s,
  input  logic            flag_z,
  input  logic            flag_pv,
  input  logic            flag_c,
  output logic            is_ret,
  output logic            take
);

  localparam int NCOND = 8;

  logic [3:0]       flag_vec;
  logic [NCOND-1:0] cc_hit;
  logic [NCOND-1:0] cc_true;
  logic             uncond;

  // index by condition bits [2:1]: 0 zero, 1 carry, 2 parity/overflow, 3 sign
  assign flag_vec = {flag_s, flag_pv, flag_c, flag_z};
  assign uncond   = (op_byte == RET_ALWAYS);

  for (genvar i = 0; i < NCOND; i++) begin : g_cc
    localparam logic [2:0] CC = 3'(i);
    assign cc_hit[i]  = (op_byte == {2'b11, CC, 3'b000});
    assign cc_true[i] = (flag_vec[CC[2:1]] == CC[0]);
  end

  assign is_ret = uncond | (|cc_hit);
  assign take   = uncond | (|(cc_hit & cc_true));

  // R4: the unconditional opcode is always recognised and always taken
  always_comb begin
    if (uncond) begin
      a_r4_uncond_taken: assert (take && is_ret);
    end
  end

  // R2: at most one condition code can match one byte
  always_comb begin
    a_r2_single_cc: assert ($countones(cc_hit) <= 1);
  end

endmodule

// File: rtl/cru_pop_fsm.sv
module cru_pop_fsm
  import cru_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       op_fire,
  input  logic       take,
  input  logic       rd_ready,
  input  logic       rd_rvalid,
  output logic       idle,
  output logic       rd_valid,
  output logic       hi_sel,
  output logic       cap_lo,
  output logic       cap_hi,
  output logic       load,
  output logic       done,
  output logic [1:0] phase
);

  seq_state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      S_IDLE:  if (op_fire) state_d = take ? S_RQ_LO : S_PASS;
      S_PASS:  state_d = S_IDLE;
      S_RQ_LO: if (rd_ready) state_d = S_WT_LO;
      S_WT_LO: if (rd_rvalid) state_d = S_RQ_HI;
      S_RQ_HI: if (rd_ready) state_d = S_WT_HI;
      S_WT_HI: if (rd_rvalid) state_d = S_LOAD;
      S_LOAD:  state_d = S_IDLE;
      default: state_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= S_IDLE;
    else        state_q <= state_d;
  end

  assign idle     = (state_q == S_IDLE);
  assign rd_valid = (state_q == S_RQ_LO) || (state_q == S_RQ_HI);
  assign hi_sel   = (state_q == S_RQ_HI);
  assign cap_lo   = (state_q == S_WT_LO) && rd_rvalid;
  assign cap_hi   = (state_q == S_WT_HI) && rd_rvalid;
  assign load     = (state_q == S_LOAD);
  assign done     = (state_q == S_PASS) || (state_q == S_LOAD);

  always_comb begin
    unique case (state_q)
      S_IDLE:                    phase = PH_IDLE;
      S_PASS, S_LOAD:            phase = PH_HANDBACK;
      default:                   phase = PH_POP;
    endcase
  end

  // R7: a hand-back lasts one cycle
  a_r7_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R3: the high-byte request always follows a completed low-byte read
  a_r3_lo_before_hi: assert property (@(posedge clk) disable iff (!rst_n)
    cap_lo |=> hi_sel);

endmodule

// File: rtl/cru_addr_path.sv
module cru_addr_path #(
  parameter int DATA_W = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                latch_sp,
  input  logic [2*DATA_W-1:0] sp_in,
  input  logic                hi_sel,
  input  logic                cap_lo,
  input  logic                cap_hi,
  input  logic [DATA_W-1:0]   rd_rdata,
  output logic [2*DATA_W-1:0] rd_addr,
  output logic [2*DATA_W-1:0] pc_out,
  output logic [2*DATA_W-1:0] sp_out
);

  localparam int AW = 2 * DATA_W;
  localparam logic [AW-1:0] ONE = AW'(1);
  localparam logic [AW-1:0] TWO = AW'(2);

  logic [AW-1:0]     sp_q;
  logic [DATA_W-1:0] lo_q;
  logic [DATA_W-1:0] hi_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sp_q <= '0;
      lo_q <= '0;
      hi_q <= '0;
    end else begin
      if (latch_sp) sp_q <= sp_in;
      if (cap_lo)   lo_q <= rd_rdata;
      if (cap_hi)   hi_q <= rd_rdata;
    end
  end

  assign rd_addr = hi_sel ? (sp_q + ONE) : sp_q;
  assign pc_out  = {hi_q, lo_q};
  assign sp_out  = sp_q + TWO;

  // R3: the low byte is never captured twice before the high byte
  a_r3_no_double_lo: assert property (@(posedge clk) disable iff (!rst_n)
    cap_lo |=> !cap_lo);

endmodule

// File: rtl/cond_return_unit.sv
module cond_return_unit
  import cru_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                op_valid,
  output logic                op_ready,
  input  logic [7:0]          op_byte,
  input  logic                flag_s,
  input  logic                flag_z,
  input  logic                flag_pv,
  input  logic                flag_c,
  input  logic [2*DATA_W-1:0] sp_in,
  output logic                rd_valid,
  input  logic                rd_ready,
  output logic [2*DATA_W-1:0] rd_addr,
  input  logic                rd_rvalid,
  input  logic [DATA_W-1:0]   rd_rdata,
  output logic                pc_we,
  output logic [2*DATA_W-1:0] pc_out,
  output logic                sp_we,
  output logic [2*DATA_W-1:0] sp_out,
  output logic                done,
  output logic [1:0]          phase_o
);

  logic is_ret, take, idle, op_fire;
  logic hi_sel, cap_lo, cap_hi, load;

  cru_cond_eval u_cond (
    .op_byte (op_byte),
    .flag_s  (flag_s),
    .flag_z  (flag_z),
    .flag_pv (flag_pv),
    .flag_c  (flag_c),
    .is_ret  (is_ret),
    .take    (take)
  );

  assign op_ready = idle && is_ret;
  assign op_fire  = op_valid && op_ready;

  cru_pop_fsm u_fsm (
    .clk       (clk),
    .rst_n     (rst_n),
    .op_fire   (op_fire),
    .take      (take),
    .rd_ready  (rd_ready),
    .rd_rvalid (rd_rvalid),
    .idle      (idle),
    .rd_valid  (rd_valid),
    .hi_sel    (hi_sel),
    .cap_lo    (cap_lo),
    .cap_hi    (cap_hi),
    .load      (load),
    .done      (done),
    .phase     (phase_o)
  );

  cru_addr_path #(.DATA_W(DATA_W)) u_addr (
    .clk      (clk),
    .rst_n    (rst_n),
    .latch_sp (op_fire),
    .sp_in    (sp_in),
    .hi_sel   (hi_sel),
    .cap_lo   (cap_lo),
    .cap_hi   (cap_hi),
    .rd_rdata (rd_rdata),
    .rd_addr  (rd_addr),
    .pc_out   (pc_out),
    .sp_out   (sp_out)
  );

  // both architectural writes fire only in the load step of a taken return
  assign pc_we = load;
  assign sp_we = load;

  // R1: acceptance only from idle
  a_r1_ready_idle: assert property (@(posedge clk) disable iff (!rst_n)
    op_ready |-> (phase_o == PH_IDLE));

  // R5: failed condition hands back next cycle without touching anything
  a_r5_pass_no_write: assert property (@(posedge clk) disable iff (!rst_n)
    (op_fire && !take) |=> (done && !pc_we && !sp_we && !rd_valid));

  // R6: after hand-back the unit is idle again
  a_r6_back_to_idle: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> (phase_o == PH_IDLE));

  // R8: a stalled request holds
  a_r8_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && !rd_ready) |=> (rd_valid && $stable(rd_addr)));

  // R9: hand-back phase and done coincide
  a_r9_phase_done: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_o == PH_HANDBACK) |-> done);

endmodule

// File: tb/cond_return_unit_bench.sv
module cond_return_unit_bench;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        op_valid = 1'b0;
  logic        op_ready;
  logic [7:0]  op_byte = 8'h00;
  logic        flag_s = 1'b0, flag_z = 1'b0, flag_pv = 1'b0, flag_c = 1'b0;
  logic [15:0] sp_in = 16'h0;
  logic        rd_valid;
  logic        rd_ready = 1'b0;
  logic [15:0] rd_addr;
  logic        rd_rvalid = 1'b0;
  logic [7:0]  rd_rdata = 8'h00;
  logic        pc_we, sp_we, done;
  logic [15:0] pc_out, sp_out;
  logic [1:0]  phase_o;

  int checks = 0;
  int failures = 0;

  always #2 clk = ~clk;

  cond_return_unit u_cond_return_unit (
    .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_ready(op_ready),
    .op_byte(op_byte), .flag_s(flag_s), .flag_z(flag_z), .flag_pv(flag_pv),
    .flag_c(flag_c), .sp_in(sp_in), .rd_valid(rd_valid), .rd_ready(rd_ready),
    .rd_addr(rd_addr), .rd_rvalid(rd_rvalid), .rd_rdata(rd_rdata),
    .pc_we(pc_we), .pc_out(pc_out), .sp_we(sp_we), .sp_out(sp_out),
    .done(done), .phase_o(phase_o)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [7:0] mem_byte(input logic [15:0] a);
    return a[7:0] ^ a[15:8] ^ 8'hA5;
  endfunction

  function automatic bit exp_take(input logic [7:0] op, input logic [3:0] f);
    // f = {s, z, pv, c}
    case (op)
      8'hC0: return !f[2];
      8'hC8: return  f[2];
      8'hD0: return !f[0];
      8'hD8: return  f[0];
      8'hE0: return !f[1];
      8'hE8: return  f[1];
      8'hF0: return !f[3];
      8'hF8: return  f[3];
      default: return 1'b1;
    endcase
  endfunction

  // memory model: stalls every third cycle, answers one cycle after accept
  logic [15:0] req_addr [4];
  int          req_n = 0;
  int          mem_cyc = 0;
  bit          hs_pending = 0;
  logic [15:0] hs_addr = 16'h0;
  bit          prev_stalled = 0;
  logic [15:0] prev_addr = 16'h0;
  bit          hold_viol = 0;

  always @(negedge clk) begin
    if (rst_n) begin
      if (prev_stalled && (!rd_valid || rd_addr != prev_addr)) hold_viol = 1;
      if (hs_pending) begin
        rd_rvalid  = 1'b1;
        rd_rdata   = mem_byte(hs_addr);
        hs_pending = 0;
      end else begin
        rd_rvalid = 1'b0;
      end
      mem_cyc++;
      rd_ready     = (mem_cyc % 3) != 0;
      prev_stalled = rd_valid && !rd_ready;
      prev_addr    = rd_addr;
      if (rd_valid && rd_ready) begin
        hs_pending = 1;
        hs_addr    = rd_addr;
        if (req_n < 4) req_addr[req_n] = rd_addr;
        req_n++;
      end
    end
  end

  bit sp_we_seen;

  task automatic run_case(input logic [7:0] op, input logic [3:0] f,
                          input logic [15:0] sp);
    bit          tk;
    int          done_k;
    int          n_done;
    logic        w_pc, w_sp;
    logic [15:0] v_pc, v_sp;
    logic [1:0]  v_ph;
    string       rq;
    tk = exp_take(op, f);
    rq = (op == 8'hC9) ? "R4" : "R2";
    done_k = 0; n_done = 0; sp_we_seen = 0;
    w_pc = 0; w_sp = 0; v_pc = 0; v_sp = 0; v_ph = 0;
    @(negedge clk);
    op_byte = op; {flag_s, flag_z, flag_pv, flag_c} = f; sp_in = sp;
    op_valid = 1'b1; req_n = 0; hold_viol = 0;
    #1;
    chk(op_ready === 1'b1, "R1", "ready for return opcode", op_ready, 1);
    @(negedge clk);
    op_valid = 1'b0;
    for (int k = 1; k <= 40; k++) begin
      if (k == 1)
        chk(phase_o == (tk ? 2'd1 : 2'd2), "R9", "phase after accept", phase_o, tk ? 1 : 2);
      if (sp_we) sp_we_seen = 1;
      if (done) begin
        n_done++;
        if (done_k == 0) begin
          done_k = k; w_pc = pc_we; w_sp = sp_we; v_pc = pc_out; v_sp = sp_out; v_ph = phase_o;
        end
      end
      if (done_k != 0 && k == done_k + 1) begin
        chk(phase_o == 2'd0, "R6", "idle after done", phase_o, 0);
        op_byte = 8'hE5; op_valid = 1'b1;
        #1;
        chk(op_ready === 1'b0, "R6", "next byte not swallowed", op_ready, 0);
        op_valid = 1'b0;
        break;
      end
      @(negedge clk);
    end
    chk(n_done == 1, "R7", "done pulses", n_done, 1);
    chk(v_ph == 2'd2, "R9", "phase at done", v_ph, 2);
    chk((done_k == 1) == !tk, rq, $sformatf("condition op=%0h flags=%0h", op, f), done_k, tk ? 6 : 1);
    chk(hold_viol == 0, "R8", "request held under stall", hold_viol, 0);
    if (!tk) begin
      chk(w_pc == 0 && w_sp == 0 && !sp_we_seen, "R5", "no write on pass", {w_pc, w_sp}, 0);
      chk(req_n == 0, "R5", "no read on pass", req_n, 0);
    end else begin
      chk(w_pc && w_sp, "R3", "write strobes", {w_pc, w_sp}, 3);
      chk(v_pc == {mem_byte(sp + 16'd1), mem_byte(sp)}, "R3", "pc value", v_pc,
          {mem_byte(sp + 16'd1), mem_byte(sp)});
      chk(v_sp == sp + 16'd2, "R3", "sp value", v_sp, sp + 16'd2);
      chk(req_n == 2 && req_addr[0] == sp && req_addr[1] == sp + 16'd1, "R3",
          "read order", req_addr[0], sp);
    end
  endtask

  initial begin
    logic [15:0] sps [4];
    logic [7:0]  ops [9];
    sps[0] = 16'h07FF; sps[1] = 16'hFFFF; sps[2] = 16'hFFFE; sps[3] = 16'h3A10;
    ops[0] = 8'hC0; ops[1] = 8'hC8; ops[2] = 8'hD0; ops[3] = 8'hD8; ops[4] = 8'hE0;
    ops[5] = 8'hE8; ops[6] = 8'hF0; ops[7] = 8'hF8; ops[8] = 8'hC9;
    repeat (3) @(negedge clk);
    #1;
    chk(phase_o == 2'd0 && !done && !rd_valid && !pc_we && !sp_we, "R9",
        "reset state", {phase_o, done, rd_valid, pc_we, sp_we}, 0);
    @(negedge clk);
    rst_n = 1'b1;
    // R1: acceptance over every byte value at idle
    for (int b = 0; b < 256; b++) begin
      bit exp_r;
      @(negedge clk);
      op_byte = 8'(b); op_valid = 1'b0;
      exp_r = (b == 8'hC9) || (b[7:6] == 2'b11 && b[2:0] == 3'b000);
      #1;
      chk(op_ready == exp_r, "R1", $sformatf("ready for byte %0h", b), op_ready, exp_r);
    end
    // R2/R3/R4/R5: all return opcodes against all flag patterns
    for (int i = 0; i < 9; i++) begin
      for (int f = 0; f < 16; f++) begin
        run_case(ops[i], 4'(f), sps[(i * 16 + f) % 4]);
      end
    end
    // R5: compare 7 with 0 leaves z, s, c, pv clear; return-if-zero falls through
    run_case(8'hC8, 4'b0000, 16'h07FF);
    begin
      logic [15:0] sp_model;
      sp_model = sp_we_seen ? sp_out : 16'h07FF;
      chk(sp_model - 16'd1 == 16'h07FE, "R5", "push high byte address", sp_model - 16'd1, 16'h07FE);
      chk(sp_model - 16'd2 == 16'h07FD, "R5", "push low byte address", sp_model - 16'd2, 16'h07FD);
    end
    repeat (2) @(negedge clk);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    checks++;
    $display("FAIL watchdog run did not finish actual=1 expected=0");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule